// File: doc/BRIEF.md
# Segmented Command and Data Bus Controller

This block sits between a host and a 64-bit associative-memory core. The host uses a 16-bit multiplexed bus with an active-low chip strobe, a write-enable line and a command-select line. The controller decodes those lines into four cycle types and holds a persistent data source and a persistent data destination. It builds 64-bit words out of 16-bit segments using separate source and destination segment counters.

Command writes go to an instruction decoder. The decoder handles one-shot register overrides, source and destination selection, configuration-set selection, a comparand-to-memory move that may take its address from a second command cycle, and a forced compare. Two configuration sets, foreground and background, hold the control word, the segment counters, the address register, mask 1 and the two persistent selections. The host switches between the sets with one instruction.

The controller raises a one-cycle compare trigger toward the search logic. Storage is modelled as plain registers and a small word memory. Everything runs on one system clock. The strobe is synchronised, and its edges become single-cycle pulses.

Top module: `seg_bus_ctrl`

## Requirements
- R1: The pair {write-enable, command-select} sampled at a strobe fall selects the cycle type: 00 command write, 01 data write, 10 command read, 11 data read. `dq_oe_o` is high only in the low phase of a read cycle, and it rises only in the clock after a detected strobe fall.
- R2: Bus lines are sampled at the detected falling edge of the strobe. Changes to `dq_i` later in the low phase have no effect.
- R3: The destination segment counter advances on the strobe rising edge after each data write, and the source segment counter advances after each data read. Both wrap from 3 to 0, and segment 0 is bits 15:0. In the segment-control override register, bits 1:0 hold the destination counter and bits 3:2 hold the source counter.
- R4: After reset, data cycles read from and write to the comparand. Instruction 0x2000|r selects source r and 0x3000|r selects destination r, where r is 0 comparand, 1 mask 1, 2 mask 2 or 3 memory. A selection holds until the next selection of the same kind.
- R5: Instruction 0x1000|t redirects only the next command cycle, read or write, to register t: 0 control, 1 page, 2 segment control, 3 address (bits 11:0), 4 next-free, 5 device select. Command cycles after that one return to the instruction decoder and to status.
- R6: Move instruction 0x5000 writes the comparand to memory at the address register. With bit 11 set (0x5800), the move waits. The next command write loads the address register and performs the move there. Status bit 14 shows a move that is waiting.
- R7: After each memory access, control bits 3:2 update the address register: 01 increments it, 10 decrements it, 00 and 11 hold it. A memory access is a data write or data read of segment 3, or a move.
- R8: A control write with bit 15 equal to 0 resets both configuration sets, the active-set choice, any pending override and any waiting move. All other bits of that write are ignored. Bit 15 always reads back as 0.
- R9: `compare_o` pulses for one cycle after each of these: a control write with bit 15 set, a data write to segment 3 of the comparand, mask 1 or mask 2, or instruction 0x6000. Memory writes and writes to other segments do not pulse it.
- R10: Instruction 0x4000 selects the foreground set and 0x4001 selects the background set. The foreground set is active after reset. Each set keeps its own control word, segment counters, address, mask 1 and selections.
- R11: A command read with no override pending returns status: bit 15 is the active set (1 = background), bit 14 is a waiting move, and bits 11:0 are the active address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_ni | input | 1 | Active-low chip strobe, asynchronous to clk_i |
| wr_ni | input | 1 | Low selects a write cycle |
| cmd_ni | input | 1 | Low selects a command cycle |
| dq_i | input | 16 | Bus data in |
| dq_o | output | 16 | Bus data out, valid while dq_oe_o is high |
| dq_oe_o | output | 1 | Output enable for the bus drivers |
| compare_o | output | 1 | One-cycle compare trigger |

## Verification
The bench sweeps every persistent destination and source through full four-segment words. A counter that fails to wrap, or advances on the wrong edge, shows up as scrambled read-back. It counts compare pulses around segment 2 and segment 3 writes, around memory writes and around control writes. A design that fires on every segment, or on a reset-type control write, gives the wrong count. Further checks cover:
- a status read right after an override access, which catches an override that lingers past one cycle;
- address stepping in all four control modes, which exposes a step taken per segment instead of per word;
- flipping between the two configuration sets, which shows state shared between them;
- changing the bus mid-cycle, which exposes sampling on the wrong edge.

// File: rtl/seg_bus_pkg.sv
package seg_bus_pkg;
  localparam int SEG_W  = 16;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 12;
  localparam int N_SEG  = WORD_W / SEG_W;
  localparam int SEG_IW = $clog2(N_SEG);

  typedef enum logic [1:0] {RES_CMP = 2'd0, RES_MSK1 = 2'd1, RES_MSK2 = 2'd2, RES_MEM = 2'd3} res_e;
  typedef enum logic [2:0] {
    OVR_CTRL = 3'd0, OVR_PAGE = 3'd1, OVR_SEG = 3'd2,
    OVR_ADDR = 3'd3, OVR_FREE = 3'd4, OVR_DSEL = 3'd5
  } ovr_e;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_OVR = 4'd1, OP_SRC = 4'd2, OP_DST = 4'd3,
    OP_SET = 4'd4, OP_MOVE = 4'd5, OP_CMP = 4'd6
  } op_e;

  typedef struct packed {
    logic [14:0]       ctrl;
    logic [SEG_IW-1:0] sseg;
    logic [SEG_IW-1:0] dseg;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] msk1;
    res_e              src;
    res_e              dst;
  } cfg_t;
endpackage

// File: rtl/seg_strobe_sync.sv
module seg_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_ni};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
  assign rise_o = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/seg_cmd_decode.sv
module seg_cmd_decode
  import seg_bus_pkg::*;
(
  input  logic [SEG_W-1:0] instr_i,
  output op_e              op_o,
  output logic             aflag_o,
  output ovr_e             ovr_o,
  output logic             ovr_ok_o,
  output res_e             res_o,
  output logic             set_bg_o
);
  always_comb begin
    op_o     = (instr_i[15:12] <= 4'd6) ? op_e'(instr_i[15:12]) : OP_NOP;
    aflag_o  = instr_i[11];
    ovr_o    = ovr_e'(instr_i[2:0]);
    ovr_ok_o = instr_i[2:0] <= 3'd5;
    res_o    = res_e'(instr_i[1:0]);
    set_bg_o = instr_i[0];
  end
endmodule

// File: rtl/seg_word_mem.sv
module seg_word_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  parameter int SW    = 16,
  parameter int SIW   = 2,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seg_we_i,
  input  logic          word_we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [SIW-1:0] seg_i,
  input  logic [SW-1:0] seg_data_i,
  input  logic [W-1:0]  word_data_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (word_we_i) begin
      mem_q[widx_i] <= word_data_i;
    end else if (seg_we_i) begin
      mem_q[widx_i][seg_i*SW +: SW] <= seg_data_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/seg_bus_ctrl.sv
module seg_bus_ctrl
  import seg_bus_pkg::*;
#(
  parameter int MEM_DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_ni,
  input  logic             wr_ni,
  input  logic             cmd_ni,
  input  logic [SEG_W-1:0] dq_i,
  output logic [SEG_W-1:0] dq_o,
  output logic             dq_oe_o,
  output logic             compare_o
);
  localparam int MIW = $clog2(MEM_DEPTH);
  localparam logic [SEG_IW-1:0] LAST_SEG = SEG_IW'(N_SEG - 1);
  localparam cfg_t CFG_RST = '{ctrl: '0, sseg: '0, dseg: '0, addr: '0, msk1: '0,
                               src: RES_CMP, dst: RES_CMP};

  logic fall_p, rise_p;
  op_e  dec_op;
  logic dec_aflag, dec_ovr_ok, dec_bg;
  ovr_e dec_ovr;
  res_e dec_res;

  cfg_t              cfg_q [2];
  cfg_t              act;
  logic              bg_q, tco_v_q, tco_use_q, pend_q, rd_en_q, cmp_q_p;
  ovr_e              tco_sel_q;
  logic [1:0]        cyc_q;
  logic [WORD_W-1:0] cmp_q, msk2_q, mem_rd, src_word;
  logic [SEG_W-1:0]  page_q, free_q, dsel_q, ovr_rd, status;
  logic              mv_direct, mv_pend, mem_seg_we;
  logic [1:0]        cyc;

  seg_strobe_sync #(.STAGES(2)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_ni(strobe_ni), .fall_o(fall_p), .rise_o(rise_p)
  );

  seg_cmd_decode i_dec (
    .instr_i(dq_i), .op_o(dec_op), .aflag_o(dec_aflag), .ovr_o(dec_ovr),
    .ovr_ok_o(dec_ovr_ok), .res_o(dec_res), .set_bg_o(dec_bg)
  );

  function automatic logic [WORD_W-1:0] put_seg(logic [WORD_W-1:0] w, logic [SEG_IW-1:0] s,
                                                logic [SEG_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = w;
    r[s*SEG_W +: SEG_W] = d;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic [1:0] mode);
    case (mode)
      2'b01:   return a + 1'b1;
      2'b10:   return a - 1'b1;
      default: return a;
    endcase
  endfunction

  assign act = cfg_q[bg_q];
  assign cyc = {wr_ni, cmd_ni};

  // memory port: segment writes from the bus, whole-word moves from the comparand
  assign mem_seg_we = fall_p && cyc == 2'b01 && act.dst == RES_MEM;
  assign mv_pend    = fall_p && cyc == 2'b00 && !tco_v_q && pend_q;
  assign mv_direct  = fall_p && cyc == 2'b00 && !tco_v_q && !pend_q &&
                      dec_op == OP_MOVE && !dec_aflag;

  seg_word_mem #(.DEPTH(MEM_DEPTH), .W(WORD_W), .SW(SEG_W), .SIW(SEG_IW), .IW(MIW)) i_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .seg_we_i(mem_seg_we), .word_we_i(mv_direct || mv_pend),
    .widx_i(mv_pend ? dq_i[MIW-1:0] : act.addr[MIW-1:0]),
    .seg_i(act.dseg), .seg_data_i(dq_i), .word_data_i(cmp_q),
    .ridx_i(act.addr[MIW-1:0]), .rdata_o(mem_rd)
  );

  always_comb begin
    case (tco_sel_q)
      OVR_CTRL: ovr_rd = {1'b0, act.ctrl};
      OVR_PAGE: ovr_rd = page_q;
      OVR_SEG:  ovr_rd = SEG_W'({act.sseg, act.dseg});
      OVR_ADDR: ovr_rd = SEG_W'(act.addr);
      OVR_FREE: ovr_rd = free_q;
      OVR_DSEL: ovr_rd = dsel_q;
      default:  ovr_rd = '0;
    endcase
    case (act.src)
      RES_CMP:  src_word = cmp_q;
      RES_MSK1: src_word = act.msk1;
      RES_MSK2: src_word = msk2_q;
      default:  src_word = mem_rd;
    endcase
    status = {bg_q, pend_q, 2'b00, act.addr};
    if (!rd_en_q)      dq_o = '0;
    else if (cyc_q[0]) dq_o = src_word[act.sseg*SEG_W +: SEG_W];
    else if (tco_v_q)  dq_o = ovr_rd;
    else               dq_o = status;
  end

  assign dq_oe_o   = rd_en_q;
  assign compare_o = cmp_q_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q[0] <= CFG_RST;
      cfg_q[1] <= CFG_RST;
      bg_q     <= 1'b0;
      tco_v_q  <= 1'b0;
      tco_use_q <= 1'b0;
      tco_sel_q <= OVR_CTRL;
      pend_q   <= 1'b0;
      rd_en_q  <= 1'b0;
      cyc_q    <= 2'b10;
      cmp_q_p  <= 1'b0;
      cmp_q    <= '0;
      msk2_q   <= '0;
      page_q   <= '0;
      free_q   <= '0;
      dsel_q   <= '0;
    end else begin
      cmp_q_p <= 1'b0;
      if (fall_p) begin
        cyc_q   <= cyc;
        rd_en_q <= wr_ni;
        case (cyc)
          2'b00: begin
            if (tco_v_q) begin
              tco_use_q <= 1'b1;
              case (tco_sel_q)
                OVR_CTRL: begin
                  if (!dq_i[15]) begin
                    cfg_q[0]  <= CFG_RST;
                    cfg_q[1]  <= CFG_RST;
                    bg_q      <= 1'b0;
                    pend_q    <= 1'b0;
                    tco_v_q   <= 1'b0;
                    tco_use_q <= 1'b0;
                  end else begin
                    cfg_q[bg_q].ctrl <= dq_i[14:0];
                    cmp_q_p <= 1'b1;
                  end
                end
                OVR_PAGE: page_q <= dq_i;
                OVR_SEG: begin
                  cfg_q[bg_q].dseg <= dq_i[SEG_IW-1:0];
                  cfg_q[bg_q].sseg <= dq_i[2*SEG_IW-1:SEG_IW];
                end
                OVR_ADDR: cfg_q[bg_q].addr <= dq_i[ADDR_W-1:0];
                OVR_FREE: free_q <= dq_i;
                OVR_DSEL: dsel_q <= dq_i;
                default: ;
              endcase
            end else if (pend_q) begin
              pend_q <= 1'b0;
              cfg_q[bg_q].addr <= step_addr(dq_i[ADDR_W-1:0], act.ctrl[3:2]);
            end else begin
              case (dec_op)
                OP_OVR: if (dec_ovr_ok) begin
                  tco_v_q   <= 1'b1;
                  tco_sel_q <= dec_ovr;
                  tco_use_q <= 1'b0;
                end
                OP_SRC:  cfg_q[bg_q].src <= dec_res;
                OP_DST:  cfg_q[bg_q].dst <= dec_res;
                OP_SET:  bg_q <= dec_bg;
                OP_MOVE: begin
                  if (dec_aflag) pend_q <= 1'b1;
                  else cfg_q[bg_q].addr <= step_addr(act.addr, act.ctrl[3:2]);
                end
                OP_CMP:  cmp_q_p <= 1'b1;
                default: ;
              endcase
            end
          end
          2'b01: begin
            case (act.dst)
              RES_CMP:  cmp_q  <= put_seg(cmp_q, act.dseg, dq_i);
              RES_MSK1: cfg_q[bg_q].msk1 <= put_seg(act.msk1, act.dseg, dq_i);
              RES_MSK2: msk2_q <= put_seg(msk2_q, act.dseg, dq_i);
              default: if (act.dseg == LAST_SEG)
                cfg_q[bg_q].addr <= step_addr(act.addr, act.ctrl[3:2]);
            endcase
            if (act.dst != RES_MEM && act.dseg == LAST_SEG) cmp_q_p <= 1'b1;
          end
          2'b10: if (tco_v_q) tco_use_q <= 1'b1;
          default: ;
        endcase
      end else if (rise_p) begin
        rd_en_q <= 1'b0;
        if (tco_use_q) begin
          tco_v_q   <= 1'b0;
          tco_use_q <= 1'b0;
        end
        if (cyc_q == 2'b01) cfg_q[bg_q].dseg <= act.dseg + 1'b1;
        if (cyc_q == 2'b11) begin
          cfg_q[bg_q].sseg <= act.sseg + 1'b1;
          if (act.src == RES_MEM && act.sseg == LAST_SEG)
            cfg_q[bg_q].addr <= step_addr(act.addr, act.ctrl[3:2]);
        end
      end
    end
  end

  // R1
  oe_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(fall_p));
  // R9
  cmp_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compare_o |-> $past(fall_p));
  // R9
  cmp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compare_o |=> !compare_o);
  // R5
  ovr_oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_p && tco_use_q) |=> !tco_v_q);
  // R6
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(fall_p));
  // R10
  set_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bg_q) |-> $past(fall_p));
  // R3
  seg_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q[0].dseg) |-> $past(fall_p || rise_p));
endmodule

// File: tb/test_seg_bus_ctrl.sv
`timescale 1ns/1ps
module test_seg_bus_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, strobe_n = 1'b1, wr_n = 1'b1, cmd_n = 1'b1;
  logic [15:0] dq = '0, dq_out;
  logic oe, cmp;
  int checks = 0, fails = 0, cmp_cnt = 0;

  always #10 clk = ~clk;

  seg_bus_ctrl i_seg_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .strobe_ni(strobe_n), .wr_ni(wr_n), .cmd_ni(cmd_n),
    .dq_i(dq), .dq_o(dq_out), .dq_oe_o(oe), .compare_o(cmp)
  );

  always @(negedge clk) if (cmp) cmp_cnt++;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic c, input logic [15:0] d,
                     output logic [15:0] q, output logic o);
    @(negedge clk); wr_n = w; cmd_n = c; dq = d;
    @(negedge clk); strobe_n = 1'b0;
    repeat (6) @(negedge clk);
    q = dq_out; o = oe;
    strobe_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cw(input logic [15:0] d);
    logic [15:0] q; logic o;
    bus(1'b0, 1'b0, d, q, o);
  endtask
  task automatic dw(input logic [15:0] d);
    logic [15:0] q; logic o;
    bus(1'b0, 1'b1, d, q, o);
  endtask
  task automatic cr(output logic [15:0] q);
    logic o;
    bus(1'b1, 1'b0, 16'h0, q, o);
  endtask
  task automatic dr(output logic [15:0] q);
    logic o;
    bus(1'b1, 1'b1, 16'h0, q, o);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic o;
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 R10: reset status
    cr(q); chk("R11 reset status", q, 16'h0000);

    // R4 R9 R1: default comparand, compare on last segment only
    for (int j = 0; j < 3; j++) dw(16'hA000 + 16'(j));
    chk("R9 no compare before last segment", 16'(cmp_cnt), 16'd0);
    bus(1'b0, 1'b1, 16'hA003, q, o);
    chk("R1 no drive in write cycle", {15'b0, o}, 16'd0);
    chk("R9 compare after comparand segment 3", 16'(cmp_cnt), 16'd1);
    for (int j = 0; j < 4; j++) begin
      bus(1'b1, 1'b1, 16'h0, q, o);
      chk("R4 default source comparand", q, 16'hA000 + 16'(j));
      chk("R1 drive in read cycle", {15'b0, o}, 16'd1);
    end

    // R3: counters wrap and step on rising edge
    cw(16'h1002); cr(q); chk("R3 counters wrapped", q, 16'h0000);
    dw(16'h5555);
    cw(16'h1002); cr(q); chk("R3 destination stepped", q, 16'h0001);
    dr(q); chk("R3 segment 0 is low bits", q, 16'h5555);
    cw(16'h1002); cr(q); chk("R3 source stepped", q, 16'h0005);
    cw(16'h1002); cw(16'h0000);
    cw(16'h1002); cr(q); chk("R3 counters loaded", q, 16'h0000);

    // R4 R9: sweep destinations and sources
    for (int k = 1; k < 4; k++) begin
      cw(16'h3000 | 16'(k)); cw(16'h2000 | 16'(k));
      c0 = cmp_cnt;
      for (int j = 0; j < 4; j++) dw(16'(k * 16'h1000 + j * 16'h11));
      chk("R9 compare count per destination", 16'(cmp_cnt - c0), (k == 3) ? 16'd0 : 16'd1);
      for (int j = 0; j < 4; j++) begin
        dr(q); chk("R4 persistent resource readback", q, 16'(k * 16'h1000 + j * 16'h11));
      end
    end
    cw(16'h3000); cw(16'h2000);

    // R5: override lasts one command cycle
    cw(16'h1003); cw(16'h0005);
    cr(q); chk("R5 status after override", q, 16'h0005);
    cw(16'h1003); cr(q); chk("R5 override read address", q, 16'h0005);

    // R7 R8 R9: address stepping modes
    c0 = cmp_cnt;
    cw(16'h1000); cw(16'h8004);
    chk("R9 compare on control write", 16'(cmp_cnt - c0), 16'd1);
    cw(16'h1000); cr(q); chk("R8 control bit 15 reads 0", q, 16'h0004);
    cw(16'h3003);
    dw(16'hB000); dw(16'hB001);
    cr(q); chk("R7 no step mid word", q, 16'h0005);
    dw(16'hB002); dw(16'hB003);
    cr(q); chk("R7 increment after word", q, 16'h0006);
    cw(16'h1000); cw(16'h8008); cw(16'h2003);
    for (int j = 0; j < 4; j++) begin dr(q); chk("R7 unwritten word", q, 16'h0000); end
    cr(q); chk("R7 decrement after read", q, 16'h0005);
    cw(16'h1000); cw(16'h800C);
    for (int j = 0; j < 4; j++) begin dr(q); chk("R7 memory word readback", q, 16'hB000 + 16'(j)); end
    cr(q); chk("R7 mode 11 holds", q, 16'h0005);
    cw(16'h1000); cw(16'h8000);

    // R6: two-cycle move
    cw(16'h3000);
    for (int j = 0; j < 4; j++) dw(16'hC000 + 16'(j));
    cw(16'h5800); cr(q); chk("R6 move waiting", q, 16'h4005);
    cw(16'h0009); cr(q); chk("R6 address loaded", q, 16'h0009);
    for (int j = 0; j < 4; j++) begin dr(q); chk("R6 moved word", q, 16'hC000 + 16'(j)); end

    // R10: foreground and background sets
    cw(16'h4001); cr(q); chk("R10 background status", q, 16'h8000);
    cw(16'h1000); cr(q); chk("R10 background control reset", q, 16'h0000);
    dr(q); chk("R10 background source comparand", q, 16'hC000);
    cw(16'h1003); cw(16'h0007);
    cw(16'h4000); cr(q); chk("R10 foreground address kept", q, 16'h0009);
    cw(16'h4001); cr(q); chk("R10 background address kept", q, 16'h8007);
    cw(16'h4000);

    // R8: soft reset through control register
    c0 = cmp_cnt;
    cw(16'h1000); cw(16'h7FFF);
    chk("R8 no compare on reset write", 16'(cmp_cnt - c0), 16'd0);
    cr(q); chk("R8 status after soft reset", q, 16'h0000);
    cw(16'h1000); cr(q); chk("R8 control cleared", q, 16'h0000);
    dr(q); chk("R8 source back to comparand", q, 16'hC000);
    cw(16'h4001); cr(q); chk("R8 background address cleared", q, 16'h8000);
    cw(16'h4000);

    // R9: forced compare, no-op instruction
    c0 = cmp_cnt;
    cw(16'h6000);
    chk("R9 forced compare", 16'(cmp_cnt - c0), 16'd1);
    cw(16'h0123);
    chk("R9 no compare on no-op", 16'(cmp_cnt - c0), 16'd1);

    // R2: data sampled at the falling edge only
    cw(16'h1002); cw(16'h0000);
    @(negedge clk); wr_n = 1'b0; cmd_n = 1'b1; dq = 16'h1234;
    @(negedge clk); strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    dq = 16'hDEAD;
    repeat (2) @(negedge clk);
    strobe_n = 1'b1;
    repeat (6) @(negedge clk);
    dr(q); chk("R2 late bus change ignored", q, 16'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule